// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous static RAM with active-low chip, output and write enables and a shared bidirectional data bus. The host asks for one word at a time: it raises a request with a direction flag, an address and write data. The controller then produces the pin-level cycle, counting its timing windows in clock cycles, and reports the end of each transfer with a one-clock completion pulse. Read data is returned on a held output.

The memory bus is split into a data-out value, a drive enable and a data-in value, so that the pad or tristate buffer can stay outside this block. A write is formed by the overlap of chip enable and write enable, both low. Its length is the larger of the write-pulse minimum and the data-setup minimum. A read holds chip and output enable low for the access window and captures the bus on the last cycle of that window. Between transfers every enable is released, so the address only ever moves while the chip is deselected.

Top module: `sram_ctrl`

## Requirements
- R1: After a clock edge with rst_n low, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe and done are 0, rdata is 0, and the controller is idle and accepts the next request.
- R2: A request accepted with we=0 holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 with mem_dq_oe=0 for exactly RD_ACCESS cycles, starting the cycle after acceptance.
- R3: A request accepted with we=1 holds mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and mem_dq_oe=1, with mem_dq_out equal to the accepted wdata, for exactly max(WR_PULSE, WR_SETUP) cycles, starting the cycle after acceptance.
- R4: mem_dq_oe is 1 only while mem_ce_n=0 and mem_we_n=0 and mem_oe_n=1, and mem_oe_n is never 0 while mem_we_n is 0.
- R5: mem_addr does not change between two consecutive cycles that both have mem_ce_n=0. During a transfer it equals the address accepted with the request.
- R6: rdata takes the value on mem_dq_in during the last cycle of the read window, and keeps its value in every other cycle.
- R7: done is 1 for exactly one cycle, the cycle right after the last access cycle of every transfer. In that cycle all three enables are 1 and mem_dq_oe is 0.
- R8: req is sampled only in the idle state. A request held high during a transfer or its done cycle starts nothing until the controller is idle again.
- R9: addr, wdata and we are latched when a request is accepted. Changing them later in the transfer has no effect on mem_addr, mem_dq_out or the kind of cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Transfer request, sampled when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Last captured read data |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Value to drive on the memory data bus |
| mem_dq_oe | output | 1 | Drive enable for the memory data bus |
| mem_dq_in | input | DATA_W | Value read from the memory data bus |

## Verification
The assertions check the pin rules on every cycle:
- the bus drive appears only inside an output-disabled write overlap;
- output enable is never low together with write enable;
- the address stays put while the chip stays selected;
- done is a single pulse with all enables released;
- every write-enable pulse lasts at least the pulse and setup minimums;
- rdata moves only after a cycle with output enable low.

The exact window lengths, the capture on the last read cycle rather than an earlier one, and the ignoring of held or changed host inputs during a transfer can only be shown by the bench's scenarios. The bench shows them against its behavioural memory, which returns wrong data until the access window has elapsed.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the asynchronous SRAM access controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package sram_ctrl_pkg;

    // Transfer phase of the controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_st_t;

    // Larger of two window lengths, used to size counters and the write overlap.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
// Transfer sequencer: accepts a request in idle, stays in the write or read
// phase for a fixed number of cycles, then spends one cycle in the done phase.
// Assumes: WR_LEN and RD_LEN are at least 1 and fit in CNT_W bits minus one.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned WR_LEN = 2,
    parameter int unsigned RD_LEN = 3,
    parameter int unsigned CNT_W  = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req,
    input  logic     we,
    output xfer_st_t st,
    output logic     accept,
    output logic     rd_last
);

    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_LEN - 1);

    logic [CNT_W-1:0] remain;
    logic             win_end;

    // Decode the acceptance and end-of-window conditions from the current phase.
    always_comb begin
        accept  = (st == ST_IDLE) && req;
        win_end = (remain == '0);
        rd_last = (st == ST_READ) && win_end;
    end

    // Advance the phase and the window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            remain <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st     <= we ? ST_WRITE : ST_READ;
                        remain <= we ? WR_LOAD : RD_LOAD;
                    end
                end
                ST_WRITE, ST_READ: begin
                    if (win_end) begin
                        st <= ST_DONE;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sram_ctrl_latch.sv
// Request holding registers: capture the host address and write data when
// a request is accepted and hold them for the whole transfer.
// Assumes: accept is a single-cycle strobe from the sequencer.
module sram_ctrl_latch #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);

    // Load address and data on acceptance only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (accept) begin
            hold_addr  <= addr;
            hold_wdata <= wdata;
        end
    end

endmodule

// File: rtl/sram_ctrl_pins.sv
// Pin decoder: turns the registered phase into memory enables and bus drive.
// Each output depends only on flip-flops, so no request input reaches a pin
// without a register in between.
// Assumes: the phase register is the only source of pin changes.
module sram_ctrl_pins
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 4
) (
    input  xfer_st_t          st,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic [DATA_W-1:0] hold_wdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              done
);

    // Map each phase onto the enable levels and the bus drive.
    always_comb begin
        mem_ce_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        done       = 1'b0;
        mem_addr   = hold_addr;
        mem_dq_out = hold_wdata;
        unique case (st)
            ST_WRITE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_READ: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_DONE:  done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_ctrl_rcap.sv
// Read capture register: samples the memory bus on the final cycle of a read
// window and holds the value until the next read completes.
// Assumes: cap_en is high for exactly one cycle per read.
module sram_ctrl_rcap #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata
);

    // Capture bus data at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (cap_en) begin
            rdata <= dq_in;
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
// Asynchronous SRAM access controller top. It turns single-word host requests
// into chip-enable/write-enable overlap writes and chip-enable/output-enable
// reads. Windows are counted in clock cycles.
// Assumes: WR_PULSE, WR_SETUP and RD_ACCESS are at least 1, and each one
// already covers the matching nanosecond minimum at the clock in use. The
// external bus buffer honours mem_dq_oe.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned WR_PULSE  = 2,
    parameter int unsigned WR_SETUP  = 1,
    parameter int unsigned RD_ACCESS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned WR_LEN = max2(WR_PULSE, WR_SETUP);
    localparam int unsigned CNT_W  = $clog2(max2(WR_LEN, RD_ACCESS) + 1);

    xfer_st_t          st;
    logic              accept;
    logic              rd_last;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;

    sram_ctrl_seq #(
        .WR_LEN (WR_LEN),
        .RD_LEN (RD_ACCESS),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .we      (we),
        .st      (st),
        .accept  (accept),
        .rd_last (rd_last)
    );

    sram_ctrl_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr       (addr),
        .wdata      (wdata),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata)
    );

    sram_ctrl_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .st         (st),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .done       (done)
    );

    sram_ctrl_rcap #(
        .DATA_W (DATA_W)
    ) u_rcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (rd_last),
        .dq_in  (mem_dq_in),
        .rdata  (rdata)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
// Pin-rule checker for the SRAM access controller, bound to the top module.
// It watches only top-level ports, so it stays independent of the internal
// structure of the controller.
// Assumes: synchronous active-low reset on rst_n.
module sram_ctrl_chk #(
    parameter int unsigned ADDR_W   = 18,
    parameter int unsigned DATA_W   = 4,
    parameter int unsigned WR_PULSE = 2,
    parameter int unsigned WR_SETUP = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [DATA_W-1:0] rdata,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dq_oe
);

    logic        pv;
    logic [15:0] wl_cnt;

    // Mark the cycles whose previous cycle was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    // Count the consecutive cycles with write enable low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || mem_we_n)  wl_cnt <= '0;
        else if (wl_cnt != '1)   wl_cnt <= wl_cnt + 1'b1;
    end

    // R4: bus drive only inside an output-disabled write overlap
    a_r4_drive_in_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pv && mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

    // R4: output enable and write enable are never low together
    a_r4_no_oe_during_we: assert property (@(posedge clk) disable iff (!rst_n)
        pv && !mem_we_n |-> mem_oe_n);

    // R5: address held while the chip stays selected
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        pv && !mem_ce_n && !$past(mem_ce_n) |-> $stable(mem_addr));

    // R7: done cycle has every enable released
    a_r7_done_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        pv && done |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pv && done |=> !done);

    // R3: every write pulse meets the pulse-width and data-setup minimums
    a_r3_pulse_min: assert property (@(posedge clk) disable iff (!rst_n)
        pv && mem_we_n && !$past(mem_we_n) |->
            (wl_cnt >= 16'(WR_PULSE)) && (wl_cnt >= 16'(WR_SETUP)));

    // R6: rdata moves only after a cycle with output enable low
    a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(mem_oe_n) |-> $stable(rdata));

endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WR_PULSE (WR_PULSE),
    .WR_SETUP (WR_SETUP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .rdata     (rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
// Bench for sram_ctrl: a behavioural transfer model and a behavioural memory,
// compared against the design's ports on every falling clock edge.
module sram_ctrl_tb;

    localparam int AW   = 18;
    localparam int DW   = 4;
    localparam int WP   = 2;
    localparam int WS   = 3;
    localparam int RA   = 3;
    localparam int WLEN = (WP > WS) ? WP : WS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          done;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .WR_PULSE(WP), .WR_SETUP(WS), .RD_ACCESS(RA)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .done(done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Behavioural memory (written from the pins) and the model's own view of it.
    logic [DW-1:0] ram[int];
    logic [DW-1:0] shadow[int];
    int            rd_age = 0;
    bit            rd_was = 0;

    // Reference model: 0 idle, 1 write, 2 read, 3 done.
    int            m_st = 0;
    int            m_left = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wd = '0;
    logic [DW-1:0] m_rd = '0;
    bit            started = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare, update the memory, then advance the model for the next edge.
    always @(negedge clk) begin
        logic [DW-1:0] v;
        cycles++;
        if (started) begin
            chk("R1/R2/R3 ce_n", 32'(mem_ce_n), 32'(!(m_st == 1 || m_st == 2)));
            chk("R2/R4 oe_n", 32'(mem_oe_n), 32'(m_st != 2));
            chk("R3/R4 we_n", 32'(mem_we_n), 32'(m_st != 1));
            chk("R3/R4 dq_oe", 32'(mem_dq_oe), 32'(m_st == 1));
            chk("R7 done", 32'(done), 32'(m_st == 3));
            chk("R6 rdata", 32'(rdata), 32'(m_rd));
            if (m_st == 1 || m_st == 2) chk("R5/R9 mem_addr", 32'(mem_addr), 32'(m_addr));
            if (m_st == 1) chk("R3/R9 dq_out", 32'(mem_dq_out), 32'(m_wd));
        end
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[int'(mem_addr)] = mem_dq_out;
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            rd_age = rd_was ? rd_age + 1 : 0;
            rd_was = 1;
            v = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : '0;
            mem_dq_in = (rd_age >= RA - 1) ? v : ~v;
        end else begin
            rd_was = 0;
            mem_dq_in = '0;
        end
        if (!rst_n) begin
            m_st = 0;
            m_rd = '0;
            started = 1;
        end else begin
            case (m_st)
                0: if (req) begin
                    m_addr = addr;
                    m_wd = wdata;
                    m_left = we ? WLEN : RA;
                    m_st = we ? 1 : 2;
                    if (we) shadow[int'(addr)] = wdata;
                end
                1: if (m_left == 1) m_st = 3; else m_left--;
                2: if (m_left == 1) begin
                    m_rd = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : '0;
                    m_st = 3;
                end else m_left--;
                default: m_st = 0;
            endcase
        end
    end

    // Issue one request for a single cycle, then wait until it has finished.
    task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #1;
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 1'b0;
        repeat (WLEN + RA + 2) @(posedge clk);
        #1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ce_n", 32'(mem_ce_n), 32'd1);
        chk("R1 reset rdata", 32'(rdata), 32'd0);
        // R2/R3/R6: basic write then read, several patterns and the address ends
        xfer(1'b1, 18'h00000, 4'hA);
        xfer(1'b0, 18'h00000, 4'h0);
        chk("R6 read back zero address", 32'(rdata), 32'hA);
        xfer(1'b1, 18'h3FFFF, 4'h5);
        xfer(1'b1, 18'h15A5A, 4'hF);
        xfer(1'b0, 18'h3FFFF, 4'h0);
        chk("R6 read back top address", 32'(rdata), 32'h5);
        xfer(1'b0, 18'h15A5A, 4'h0);
        chk("R6 read back mid address", 32'(rdata), 32'hF);
        xfer(1'b0, 18'h01234, 4'h0);
        chk("R6 read unwritten", 32'(rdata), 32'h0);
        // R8: request held high across several transfers; only idle accepts
        @(posedge clk); #1;
        req = 1'b1; we = 1'b1; addr = 18'h00042; wdata = 4'h3;
        repeat (2 * (WLEN + 2)) @(posedge clk);
        #1 we = 1'b0;
        repeat (2 * (RA + 2)) @(posedge clk);
        #1 req = 1'b0;
        repeat (RA + 3) @(posedge clk);
        #1;
        chk("R8 held request read", 32'(rdata), 32'h3);
        // R9: change host inputs during a transfer
        @(posedge clk); #1;
        req = 1'b1; we = 1'b1; addr = 18'h00777; wdata = 4'h9;
        @(posedge clk); #1;
        req = 1'b0; we = 1'b0; addr = 18'h00111; wdata = 4'h6;
        repeat (WLEN + 3) @(posedge clk);
        #1;
        xfer(1'b0, 18'h00777, 4'h0);
        chk("R9 latched write data", 32'(rdata), 32'h9);
        xfer(1'b0, 18'h00111, 4'h0);
        chk("R9 no stray write", 32'(rdata), 32'h0);
        // R1: reset in the middle of a write
        @(posedge clk); #1;
        req = 1'b1; we = 1'b1; addr = 18'h00200; wdata = 4'hC;
        @(posedge clk); #1;
        req = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-write we_n", 32'(mem_we_n), 32'd1);
        chk("R1 reset mid-write dq_oe", 32'(mem_dq_oe), 32'd0);
        xfer(1'b1, 18'h00201, 4'h7);
        xfer(1'b0, 18'h00201, 4'h0);
        chk("R1 accepts after reset", 32'(rdata), 32'h7);
        repeat (4) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule